// File: doc/BRIEF.md
# Terminal Line Dataset Control

This block tracks the modem handshake state of one asynchronous terminal line. It keeps the dataset-related bits of the line's receiver control/status word. Software writes set the terminal-ready (DTR), request-to-send, secondary-transmit and interrupt-enable controls. The far end of the line reports that it has come up or gone away. From these, the block derives ring, carrier detect and clear-to-send, and raises a dataset-change flag.

When software enables dataset interrupts, each dataset change also raises an interrupt request. Reading the control/status word retires the flag and the request. Dropping DTR on a live line asks the line driver to hang up. A modem-option strap picks between the full modem view and a plain line. On a plain line only the receive interrupt enable is visible.

All pins are plain control and status levels or single-cycle strobes. There is no streamed data path, so no valid/ready handshake applies. Every update lands on the clock edge after the strobe that caused it. Inside one cycle, the events are applied in this order: read clear, register write, remote connect, remote disconnect. A line clear overrides all of them.

Top module: `dataset_ctl`

## Requirements
- R1: After reset, `csr_view` is 0, and `ds_irq` and `hangup_req` are 0.
- R2: A write stores bit 6 (receive interrupt enable), bit 5 (dataset interrupt enable), bit 3 (secondary transmit), bit 2 (RTS) and bit 1 (DTR). Written values of bits 15, 14, 13 and 12 are ignored.
- R3: A write that raises DTR while `line_up` is 1 sets carrier detect (bit 12), CTS (bit 13) and the dataset-change flag (bit 15), and clears ring (bit 14). If the written bit 5 is 1, it also raises `ds_irq`.
- R4: A write that drops DTR while `line_up` is 1 pulses `hangup_req` for one cycle. If carrier detect was set, it sets the dataset-change flag, and raises `ds_irq` when the written bit 5 is 1.
- R5: Any DTR-changing write other than the one in R3 clears carrier detect, ring and CTS. When `line_up` is 0, no hang-up is requested.
- R6: A connect pulse while DTR is 1 sets carrier detect, CTS and the dataset-change flag. It raises `ds_irq` if dataset interrupts are enabled.
- R7: A connect pulse while DTR is 0 sets ring and the dataset-change flag, and leaves carrier detect at 0. It raises `ds_irq` if dataset interrupts are enabled.
- R8: A disconnect pulse sets the dataset-change flag, and raises `ds_irq` when enabled, only if carrier detect was 1. It always clears carrier detect, ring and CTS.
- R9: A read strobe clears the dataset-change flag and `ds_irq` on the next edge. A connect in the same cycle sets them again.
- R10: Writing bit 5 as 0 withdraws `ds_irq`. Writing it as 1 while the dataset-change flag is set raises `ds_irq`.
- R11: A line clear with the modem option on keeps DTR and clears every other bit and `ds_irq`.
- R12: With `modem_en` at 0, `csr_view` shows only bit 6. Writes, connects and disconnects leave every modem bit and `ds_irq` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| modem_en | input | 1 | Modem option strap |
| line_up | input | 1 | Far end currently connected |
| csr_wr | input | 1 | Write strobe for the control/status word |
| csr_wdata | input | 16 | Write data |
| csr_rd | input | 1 | Read strobe for the control/status word |
| rmt_connect | input | 1 | One-cycle pulse: far end came up |
| rmt_disconnect | input | 1 | One-cycle pulse: far end went away |
| line_clear | input | 1 | One-cycle line reset |
| csr_view | output | 16 | Readable control/status word |
| hangup_req | output | 1 | One-cycle hang-up request |
| ds_irq | output | 1 | Dataset interrupt request |

## Verification
The read that retires the dataset-change flag can fall in the same cycle as a remote connect that sets it again. The bench provokes this by pulsing `csr_rd` and `rmt_connect` together after an earlier flag has been left pending. It then expects the flag and `ds_irq` to be set one edge later, not cleared. A reference model in the bench applies the events in the stated order, and a scoreboard compares every cycle's word, request and hang-up pulse against that model.

// File: rtl/ds_pkg.sv
package ds_pkg;
  localparam int CSR_W    = 16;
  localparam int B_DSCHG  = 15;
  localparam int B_RING   = 14;
  localparam int B_CTS    = 13;
  localparam int B_CARR   = 12;
  localparam int B_RIE    = 6;
  localparam int B_DSIE   = 5;
  localparam int B_STX    = 3;
  localparam int B_RTS    = 2;
  localparam int B_DTR    = 1;

  typedef struct packed {
    logic dschg;
    logic ring;
    logic cts;
    logic carr;
    logic rie;
    logic dsie;
    logic stx;
    logic rts;
    logic dtr;
    logic irq;
  } ds_state_t;

  typedef struct packed {
    logic rie;
    logic dsie;
    logic stx;
    logic rts;
    logic dtr;
  } ds_wfields_t;
endpackage

// File: rtl/ds_csr_write.sv
module ds_csr_write
  import ds_pkg::*;
(
  input  logic        wr_en,
  input  logic        modem_en,
  input  logic        line_up,
  input  ds_wfields_t wf,
  input  ds_state_t   st_i,
  output ds_state_t   st_o,
  output logic        hang_o
);
  logic dtr_moves;
  assign dtr_moves = wf.dtr ^ st_i.dtr;

  always_comb begin
    st_o   = st_i;
    hang_o = 1'b0;
    if (wr_en) begin
      st_o.rie = wf.rie;
      if (modem_en) begin
        // interrupt enable gating of a pending change
        if (!wf.dsie) st_o.irq = 1'b0;
        else if (st_i.dschg) st_o.irq = 1'b1;
        if (dtr_moves) begin
          if (wf.dtr && line_up) begin
            st_o.ring  = 1'b0;
            st_o.carr  = 1'b1;
            st_o.cts   = 1'b1;
            st_o.dschg = 1'b1;
            if (wf.dsie) st_o.irq = 1'b1;
          end else begin
            if (line_up) begin
              hang_o = 1'b1;
              if (st_i.carr) begin
                st_o.dschg = 1'b1;
                if (wf.dsie) st_o.irq = 1'b1;
              end
            end
            st_o.carr = 1'b0;
            st_o.ring = 1'b0;
            st_o.cts  = 1'b0;
          end
        end
        st_o.dsie = wf.dsie;
        st_o.stx  = wf.stx;
        st_o.rts  = wf.rts;
        st_o.dtr  = wf.dtr;
      end
    end
  end
endmodule

// File: rtl/ds_remote_event.sv
module ds_remote_event
  import ds_pkg::*;
(
  input  logic      modem_en,
  input  logic      conn_p,
  input  logic      disc_p,
  input  ds_state_t st_i,
  output ds_state_t st_o
);
  always_comb begin
    st_o = st_i;
    if (modem_en && conn_p) begin
      if (st_i.dtr) begin
        st_o.carr = 1'b1;
        st_o.cts  = 1'b1;
        st_o.ring = 1'b0;
      end else begin
        st_o.ring = 1'b1;
      end
      st_o.dschg = 1'b1;
      if (st_i.dsie) st_o.irq = 1'b1;
    end
    if (modem_en && disc_p) begin
      if (st_o.carr) begin
        st_o.dschg = 1'b1;
        if (st_o.dsie) st_o.irq = 1'b1;
      end
      st_o.carr = 1'b0;
      st_o.ring = 1'b0;
      st_o.cts  = 1'b0;
    end
  end
endmodule

// File: rtl/ds_csr_view.sv
module ds_csr_view
  import ds_pkg::*;
(
  input  logic             modem_en,
  input  ds_state_t        st,
  output logic [CSR_W-1:0] view
);
  always_comb begin
    view         = '0;
    view[B_RIE]  = st.rie;
    if (modem_en) begin
      view[B_DSCHG] = st.dschg;
      view[B_RING]  = st.ring;
      view[B_CTS]   = st.cts;
      view[B_CARR]  = st.carr;
      view[B_DSIE]  = st.dsie;
      view[B_STX]   = st.stx;
      view[B_RTS]   = st.rts;
      view[B_DTR]   = st.dtr;
    end
  end
endmodule

// File: rtl/dataset_ctl.sv
module dataset_ctl
  import ds_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             modem_en,
  input  logic             line_up,
  input  logic             csr_wr,
  input  logic [CSR_W-1:0] csr_wdata,
  input  logic             csr_rd,
  input  logic             rmt_connect,
  input  logic             rmt_disconnect,
  input  logic             line_clear,
  output logic [CSR_W-1:0] csr_view,
  output logic             hangup_req,
  output logic             ds_irq
);
  ds_state_t   st_q, st_rd, st_wr, st_ev, st_d;
  ds_wfields_t wf;
  logic        hang_c;
  logic        unused_wbits;

  assign wf.rie  = csr_wdata[B_RIE];
  assign wf.dsie = csr_wdata[B_DSIE];
  assign wf.stx  = csr_wdata[B_STX];
  assign wf.rts  = csr_wdata[B_RTS];
  assign wf.dtr  = csr_wdata[B_DTR];
  assign unused_wbits = ^{csr_wdata[CSR_W-1:B_RIE+1], csr_wdata[B_DSIE-1], csr_wdata[0]};

  // read retires the pending change before any new event is applied
  always_comb begin
    st_rd = st_q;
    if (csr_rd) begin
      st_rd.dschg = 1'b0;
      st_rd.irq   = 1'b0;
    end
  end

  ds_csr_write u_wr (
    .wr_en   (csr_wr),
    .modem_en(modem_en),
    .line_up (line_up),
    .wf      (wf),
    .st_i    (st_rd),
    .st_o    (st_wr),
    .hang_o  (hang_c)
  );

  ds_remote_event u_ev (
    .modem_en(modem_en),
    .conn_p  (rmt_connect),
    .disc_p  (rmt_disconnect),
    .st_i    (st_wr),
    .st_o    (st_ev)
  );

  always_comb begin
    st_d = st_ev;
    if (line_clear) begin
      st_d     = '0;
      st_d.dtr = modem_en & st_q.dtr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= '0;
      hangup_req <= 1'b0;
    end else begin
      st_q       <= st_d;
      hangup_req <= hang_c & ~line_clear;
    end
  end

  ds_csr_view u_view (
    .modem_en(modem_en),
    .st      (st_q),
    .view    (csr_view)
  );

  assign ds_irq = st_q.irq & modem_en;

  // R4: hang-up is a single pulse and leaves DTR low
  a_r4_hangup_single: assert property (@(posedge clk) disable iff (!rst_n)
    hangup_req |=> !hangup_req);
  a_r4_hangup_dtr_low: assert property (@(posedge clk) disable iff (!rst_n)
    hangup_req |-> !st_q.dtr);
  // R6: clear-to-send accompanies carrier detect
  a_r6_cts_with_carr: assert property (@(posedge clk) disable iff (!rst_n)
    st_q.carr |-> st_q.cts);
  // R7: ring and carrier never coexist
  a_r7_ring_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_q.ring && st_q.carr));
  // R8: disconnect drops the line status
  a_r8_disc_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (modem_en && rmt_disconnect) |=> (!st_q.carr && !st_q.ring && !st_q.cts));
  // R9: a lone read retires flag and request
  a_r9_read_retires: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rd && !csr_wr && !rmt_connect && !rmt_disconnect) |=> (!st_q.dschg && !st_q.irq));
  // R11: line clear drops request and carrier
  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
    line_clear |=> (!st_q.irq && !st_q.carr && !hangup_req));
endmodule

// File: tb/dataset_ctl_test.sv
module dataset_ctl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        modem_en = 1'b1;
  logic        line_up = 1'b0;
  logic        csr_wr = 1'b0;
  logic [15:0] csr_wdata = '0;
  logic        csr_rd = 1'b0;
  logic        rmt_connect = 1'b0;
  logic        rmt_disconnect = 1'b0;
  logic        line_clear = 1'b0;
  logic [15:0] csr_view;
  logic        hangup_req;
  logic        ds_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  dataset_ctl uut (
    .clk(clk), .rst_n(rst_n), .modem_en(modem_en), .line_up(line_up),
    .csr_wr(csr_wr), .csr_wdata(csr_wdata), .csr_rd(csr_rd),
    .rmt_connect(rmt_connect), .rmt_disconnect(rmt_disconnect),
    .line_clear(line_clear), .csr_view(csr_view),
    .hangup_req(hangup_req), .ds_irq(ds_irq)
  );

  typedef struct {
    logic [15:0] view;
    logic        irq;
    logic        hang;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fail = 0;
  bit   finished = 0;

  // reference model state
  logic m_chg, m_ring, m_cts, m_carr, m_rie, m_dsie, m_stx, m_rts, m_dtr, m_irq;

  function automatic logic [15:0] model_view(input logic modem);
    logic [15:0] v;
    v = '0;
    v[6] = m_rie;
    if (modem) begin
      v[15] = m_chg; v[14] = m_ring; v[13] = m_cts; v[12] = m_carr;
      v[5] = m_dsie; v[3] = m_stx; v[2] = m_rts; v[1] = m_dtr;
    end
    return v;
  endfunction

  task automatic step(input logic rd, input logic wr, input logic [15:0] wd,
                      input logic conn, input logic disc, input logic up,
                      input logic clr, input logic modem, input string tag);
    exp_t e;
    logic hang;
    logic dtr_old;
    @(negedge clk);
    csr_rd = rd; csr_wr = wr; csr_wdata = wd; rmt_connect = conn;
    rmt_disconnect = disc; line_up = up; line_clear = clr; modem_en = modem;
    dtr_old = m_dtr;
    hang = 1'b0;
    if (rd) begin m_chg = 0; m_irq = 0; end
    if (wr) begin
      m_rie = wd[6];
      if (modem) begin
        if (!wd[5]) m_irq = 0;
        else if (m_chg) m_irq = 1;
        if (wd[1] != m_dtr) begin
          if (wd[1] && up) begin
            m_carr = 1; m_cts = 1; m_chg = 1; m_ring = 0;
            if (wd[5]) m_irq = 1;
          end else begin
            if (up) begin
              hang = 1;
              if (m_carr) begin m_chg = 1; if (wd[5]) m_irq = 1; end
            end
            m_carr = 0; m_cts = 0; m_ring = 0;
          end
        end
        m_dsie = wd[5]; m_stx = wd[3]; m_rts = wd[2]; m_dtr = wd[1];
      end
    end
    if (modem && conn) begin
      if (m_dtr) begin m_carr = 1; m_cts = 1; end
      else m_ring = 1;
      m_chg = 1;
      if (m_dsie) m_irq = 1;
    end
    if (modem && disc) begin
      if (m_carr) begin m_chg = 1; if (m_dsie) m_irq = 1; end
      m_carr = 0; m_cts = 0; m_ring = 0;
    end
    if (clr) begin
      {m_chg, m_ring, m_cts, m_carr, m_rie, m_dsie, m_stx, m_rts, m_irq} = '0;
      m_dtr = modem & dtr_old;
      hang = 0;
    end
    e.view = model_view(modem);
    e.irq  = m_irq & modem;
    e.hang = hang;
    e.tag  = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle(input logic up, input logic modem, input string tag);
    step(0, 0, 16'h0000, 0, 0, up, 0, modem, tag);
  endtask

  // monitor: sample after each active edge and compare against the scoreboard
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        n_checks++;
        if (csr_view !== e.view) begin
          n_fail++;
          $display("FAIL %s csr_view actual=%h expected=%h", e.tag, csr_view, e.view);
        end
        n_checks++;
        if (ds_irq !== e.irq) begin
          n_fail++;
          $display("FAIL %s ds_irq actual=%b expected=%b", e.tag, ds_irq, e.irq);
        end
        n_checks++;
        if (hangup_req !== e.hang) begin
          n_fail++;
          $display("FAIL %s hangup_req actual=%b expected=%b", e.tag, hangup_req, e.hang);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    {m_chg, m_ring, m_cts, m_carr, m_rie, m_dsie, m_stx, m_rts, m_dtr, m_irq} = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    idle(0, 1, "R1 reset state");
    // R2: read-only bits ignored; DTR rises with line down
    step(0, 1, 16'hFFFF, 0, 0, 0, 0, 1, "R2 write all ones");
    idle(0, 1, "R2 hold");
    // R5: DTR drop with line down, no hang-up
    step(0, 1, 16'h0000, 0, 0, 0, 0, 1, "R5 drop dtr line down");
    step(0, 1, 16'h0020, 0, 0, 0, 0, 1, "R2 enable ds irq");
    // R7: connect with DTR low rings
    step(0, 0, 16'h0000, 1, 0, 1, 0, 1, "R7 connect ring");
    step(1, 0, 16'h0000, 0, 0, 1, 0, 1, "R9 read clears");
    // R3: raise DTR on live line
    step(0, 1, 16'h0022, 0, 0, 1, 0, 1, "R3 dtr rise connected");
    // R10: disable then re-enable with flag pending
    step(0, 1, 16'h0002, 0, 0, 1, 0, 1, "R10 dsie off withdraws");
    step(0, 1, 16'h0022, 0, 0, 1, 0, 1, "R10 dsie on raises");
    step(1, 0, 16'h0000, 0, 0, 1, 0, 1, "R9 read clears");
    // R4: drop DTR on live line with carrier
    step(0, 1, 16'h0020, 0, 0, 1, 0, 1, "R4 dtr drop hang-up");
    idle(1, 1, "R4 pulse ends");
    step(1, 0, 16'h0000, 0, 0, 1, 0, 1, "R9 read clears");
    // R8: disconnect without carrier
    step(0, 0, 16'h0000, 0, 1, 0, 0, 1, "R8 disconnect no carrier");
    step(1, 0, 16'h0000, 0, 0, 0, 0, 1, "R9 read clears");
    // R6: connect with DTR already high
    step(0, 1, 16'h0026, 0, 0, 0, 0, 1, "R5 dtr rise line down");
    step(0, 0, 16'h0000, 1, 0, 1, 0, 1, "R6 connect carrier");
    // R9: read and connect in same cycle; connect wins
    step(1, 0, 16'h0000, 1, 0, 1, 0, 1, "R9 read with connect");
    step(1, 0, 16'h0000, 0, 0, 1, 0, 1, "R9 read clears");
    // R8: disconnect with carrier
    step(0, 0, 16'h0000, 0, 1, 0, 0, 1, "R8 disconnect carrier");
    step(0, 1, 16'h006E, 0, 0, 0, 0, 1, "R2 write controls");
    // R11: line clear keeps DTR only
    step(0, 0, 16'h0000, 0, 0, 0, 1, 1, "R11 line clear");
    idle(0, 1, "R11 hold");
    // R12: plain line
    step(0, 1, 16'hFFFD, 0, 0, 0, 0, 0, "R12 plain write");
    step(0, 0, 16'h0000, 1, 0, 1, 0, 0, "R12 plain connect");
    step(0, 1, 16'h0000, 0, 0, 1, 0, 0, "R12 plain dtr write");
    step(0, 0, 16'h0000, 0, 1, 0, 0, 0, "R12 plain disconnect");
    idle(0, 0, "R12 hold");
    idle(0, 0, "end");
    repeat (3) @(posedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule